// File: doc/BRIEF.md
# ECC-Protected Doubleword SRAM with Uncorrectable-Error Dispatch

This block is an on-chip SRAM whose words are 64 data bits wide. Each word is stored with eight check bits of an extended Hamming (72,64) code. The check bits are generated on every write. On every read they are evaluated: a single flipped bit anywhere in the 72-bit codeword is repaired before the data is returned, and a word with two flipped bits is reported as uncorrectable. A corrected read pulses a status output and records the address of the word that failed. The stored copy is left as it is, so the next read of that word corrects it again.

After reset the array holds garbage. A sequencer therefore writes a valid all-zero codeword into every location, and the block accepts no request until that pass is complete. An uncorrectable read is passed to a dispatcher, which chooses the processor outcome from two enable bits (external-interrupt enable, machine-check enable) and the access type. The outcome is one of: a machine-check exception, a data-storage exception, an instruction-storage exception, or a terminal stopped state that only reset clears. When reporting is enabled, the dispatcher also pulses a request towards the interrupt controller. A diagnostic mask input lets any codeword bits be flipped as a word is written, so that faults can be placed on purpose.

Top module: `ecc_sram`

## Requirements
- R1: After reset `ready` stays low while the scrub pass writes all 2^ADDR_W locations. It rises on the (2^ADDR_W + 2)-th rising edge after `rst_n` is released. Until then requests produce no `rvalid` and no `wr_err`.
- R2: Once the scrub pass has finished, every location reads as all-zero data, with no correctable or uncorrectable indication.
- R3: A full write (`wbe` all ones) followed by a read returns the written data. `rvalid` is high for one cycle, on the second rising edge after the edge that samples the read.
- R4: If exactly one bit of the stored codeword is flipped (`inj_mask` bits 63:0 map to data bits, bits 71:64 to check bits), the read returns the original data. `ce_pulse` is high for that one cycle and `ce_addr` takes the read address. `ce_addr` holds its value between corrections.
- R5: If exactly two bits of the stored codeword are flipped, the read is uncorrectable and `ce_pulse` stays low.
- R6: An uncorrectable read with `msr_ee`=1 pulses `exc_valid` with `exc_vec`=2 for a data access (`ifetch`=0) and `exc_vec`=3 for an instruction fetch (`ifetch`=1), whatever `msr_me` is.
- R7: An uncorrectable read with `msr_ee`=0 and `msr_me`=1 pulses `exc_valid` with `exc_vec`=1, for either access type.
- R8: An uncorrectable read with `msr_ee`=0 and `msr_me`=0 sets `checkstop` and does not pulse `exc_valid`. `checkstop` then stays high and `ready` stays low, with all requests ignored, until reset.
- R9: `intc_req` pulses together with an uncorrectable result only when `rpt_en` was 1 with the read. The exception outcome is the same either way.
- R10: A write with any `wbe` bit low stores nothing and pulses `wr_err` on the next rising edge. A full write leaves `wr_err` low.
- R11: A correction does not repair the stored word, so reading it again reports `ce_pulse` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | 64 | Write data |
| wbe | input | 8 | Byte enables; all must be set for a write to be stored |
| inj_mask | input | 72 | Codeword bits flipped on write (diagnostic) |
| ifetch | input | 1 | Read is an instruction fetch |
| msr_ee | input | 1 | External-interrupt enable of the processor |
| msr_me | input | 1 | Machine-check enable of the processor |
| rpt_en | input | 1 | Uncorrectable-error reporting to the interrupt controller |
| ready | output | 1 | Scrub done and not stopped; requests are accepted |
| rvalid | output | 1 | Read data valid |
| rdata | output | 64 | Read data (corrected) |
| ce_pulse | output | 1 | Corrected single-bit error |
| ce_addr | output | ADDR_W | Address of the last corrected read |
| exc_valid | output | 1 | Exception signalled |
| exc_vec | output | 2 | 1 machine check, 2 data storage, 3 instruction storage |
| checkstop | output | 1 | Terminal stop state |
| intc_req | output | 1 | Interrupt-controller request pulse |
| wr_err | output | 1 | Rejected partial write |

## Verification
The assertions take the enable bits and access type presented with a read as the values that govern its outcome. They also assume that no codeword ever carries three or more flipped bits, because such words can alias to a false correction. The stimulus only ever flips zero, one or two distinct bits, and it overwrites a word with a fresh full write before placing new faults. Random traffic keeps machine-check or external-interrupt enable set, so the terminal stop state is reached only in a directed phase that finishes with a reset.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;

  localparam int DATA_W = 64;
  localparam int HAM_W  = 7;
  localparam int CHK_W  = HAM_W + 1;
  localparam int CW_W   = DATA_W + CHK_W;
  localparam int BE_W   = DATA_W / 8;

  typedef enum logic [1:0] {
    VEC_NONE = 2'd0,
    VEC_MCHK = 2'd1,
    VEC_DSI  = 2'd2,
    VEC_ISI  = 2'd3
  } exc_vec_e;

  typedef logic [DATA_W-1:0][HAM_W-1:0] pos_tab_t;

  // Hamming position of each data bit: the non-power-of-two slots 3..71.
  function automatic pos_tab_t build_pos();
    pos_tab_t t;
    int n;
    t = '0;
    n = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        t[n] = HAM_W'(p);
        n++;
      end
    end
    return t;
  endfunction

  localparam pos_tab_t DPOS = build_pos();

  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (d[i]) h = h ^ DPOS[i];
    end
    return h;
  endfunction

  // Check byte: [6:0] Hamming bits, [7] overall parity of the codeword.
  function automatic logic [CHK_W-1:0] enc_chk(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = ham_bits(d);
    return {^{d, h}, h};
  endfunction

endpackage

// File: rtl/ecc_sram_init.sv
module ecc_sram_init #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              done
);

  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic              done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!done_q) begin
      if (cnt_q == {ADDR_W{1'b1}}) done_d = 1'b1;
      else                         cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign wr_en   = !done_q;
  assign wr_addr = cnt_q;
  assign done    = done_q;

endmodule

// File: rtl/ecc_sram_dec.sv
module ecc_sram_dec
  import ecc_sram_pkg::*;
(
  input  logic [CW_W-1:0]   cw,
  output logic [DATA_W-1:0] data,
  output logic              sbe,
  output logic              dbe
);

  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] flip;
  logic [HAM_W-1:0]  syn;
  logic              par;
  logic              in_range;

  always_comb begin
    raw      = cw[DATA_W-1:0];
    syn      = cw[DATA_W +: HAM_W] ^ ham_bits(raw);
    par      = ^cw;
    in_range = (syn < HAM_W'(CW_W));
    for (int i = 0; i < DATA_W; i++) begin
      flip[i] = par && (syn == DPOS[i]);
    end
    data = raw ^ flip;
    sbe  = par && in_range;
    dbe  = (!par && (syn != '0)) || (par && !in_range);
  end

endmodule

// File: rtl/ecc_sram_disp.sv
module ecc_sram_disp
  import ecc_sram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ue,
  input  logic       ifetch,
  input  logic       ee,
  input  logic       me,
  input  logic       rpt,
  output logic       exc_fire,
  output logic [1:0] vec,
  output logic       irq,
  output logic       chkstop
);

  logic stop_hit;
  logic chk_q, chk_d;

  always_comb begin
    exc_fire = 1'b0;
    vec      = VEC_NONE;
    stop_hit = 1'b0;
    if (ue) begin
      if (ee) begin
        exc_fire = 1'b1;
        vec      = ifetch ? VEC_ISI : VEC_DSI;
      end else if (me) begin
        exc_fire = 1'b1;
        vec      = VEC_MCHK;
      end else begin
        stop_hit = 1'b1;
      end
    end
    irq   = ue && rpt;
    chk_d = chk_q || stop_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_q <= 1'b0;
    else        chk_q <= chk_d;
  end

  assign chkstop = chk_q;

endmodule

// File: rtl/ecc_sram.sv
module ecc_sram
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   wbe,
  input  logic [CW_W-1:0]   inj_mask,
  input  logic              ifetch,
  input  logic              msr_ee,
  input  logic              msr_me,
  input  logic              rpt_en,
  output logic              ready,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic              ce_pulse,
  output logic [ADDR_W-1:0] ce_addr,
  output logic              exc_valid,
  output logic [1:0]        exc_vec,
  output logic              checkstop,
  output logic              intc_req,
  output logic              wr_err
);

  localparam int DEPTH = 1 << ADDR_W;

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync_n = rs2_q;

  // scrub sequencer
  logic              init_we;
  logic [ADDR_W-1:0] init_addr;
  logic              init_done;

  ecc_sram_init #(.ADDR_W(ADDR_W)) u_init (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (init_we),
    .wr_addr (init_addr),
    .done    (init_done)
  );

  logic chk_state;
  logic acc, wr_ok, wr_bad, rd_go;

  assign ready  = init_done && !chk_state;
  assign acc    = req && ready;
  assign wr_ok  = acc && we && (&wbe);
  assign wr_bad = acc && we && !(&wbe);
  assign rd_go  = acc && !we;

  // storage and read stage
  logic [CW_W-1:0] mem [DEPTH];
  logic [CW_W-1:0] a_cw_q;

  always_ff @(posedge clk) begin
    if (init_we)
      mem[init_addr] <= {enc_chk({DATA_W{1'b0}}), {DATA_W{1'b0}}};
    else if (wr_ok)
      mem[addr] <= {enc_chk(wdata), wdata} ^ inj_mask;
    if (rd_go)
      a_cw_q <= mem[addr];
  end

  logic              a_vld_q, a_vld_d;
  logic [ADDR_W-1:0] a_addr_q, a_addr_d;
  logic              a_if_q, a_if_d, a_ee_q, a_ee_d, a_me_q, a_me_d, a_rpt_q, a_rpt_d;

  always_comb begin
    a_vld_d  = rd_go;
    a_addr_d = a_addr_q;
    a_if_d   = a_if_q;
    a_ee_d   = a_ee_q;
    a_me_d   = a_me_q;
    a_rpt_d  = a_rpt_q;
    if (rd_go) begin
      a_addr_d = addr;
      a_if_d   = ifetch;
      a_ee_d   = msr_ee;
      a_me_d   = msr_me;
      a_rpt_d  = rpt_en;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      a_vld_q  <= 1'b0;
      a_addr_q <= '0;
      a_if_q   <= 1'b0;
      a_ee_q   <= 1'b0;
      a_me_q   <= 1'b0;
      a_rpt_q  <= 1'b0;
    end else begin
      a_vld_q  <= a_vld_d;
      a_addr_q <= a_addr_d;
      a_if_q   <= a_if_d;
      a_ee_q   <= a_ee_d;
      a_me_q   <= a_me_d;
      a_rpt_q  <= a_rpt_d;
    end
  end

  // decode and dispatch
  logic [DATA_W-1:0] dec_data;
  logic              dec_sbe, dec_dbe;

  ecc_sram_dec u_dec (
    .cw   (a_cw_q),
    .data (dec_data),
    .sbe  (dec_sbe),
    .dbe  (dec_dbe)
  );

  logic       ue_go, d_fire, d_irq;
  logic [1:0] d_vec;

  assign ue_go = a_vld_q && dec_dbe;

  ecc_sram_disp u_disp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ue       (ue_go),
    .ifetch   (a_if_q),
    .ee       (a_ee_q),
    .me       (a_me_q),
    .rpt      (a_rpt_q),
    .exc_fire (d_fire),
    .vec      (d_vec),
    .irq      (d_irq),
    .chkstop  (chk_state)
  );

  // result stage
  logic              rv_q, rv_d, ce_q, ce_d, exc_q, exc_d, irq_q, irq_d, werr_q, werr_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic [ADDR_W-1:0] cea_q, cea_d;
  logic [1:0]        vec_q, vec_d;

  always_comb begin
    rv_d   = a_vld_q;
    rd_d   = a_vld_q ? dec_data : rd_q;
    ce_d   = a_vld_q && dec_sbe;
    cea_d  = (a_vld_q && dec_sbe) ? a_addr_q : cea_q;
    exc_d  = d_fire;
    vec_d  = d_fire ? d_vec : 2'd0;
    irq_d  = d_irq;
    werr_d = wr_bad;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rv_q   <= 1'b0;
      rd_q   <= '0;
      ce_q   <= 1'b0;
      cea_q  <= '0;
      exc_q  <= 1'b0;
      vec_q  <= 2'd0;
      irq_q  <= 1'b0;
      werr_q <= 1'b0;
    end else begin
      rv_q   <= rv_d;
      rd_q   <= rd_d;
      ce_q   <= ce_d;
      cea_q  <= cea_d;
      exc_q  <= exc_d;
      vec_q  <= vec_d;
      irq_q  <= irq_d;
      werr_q <= werr_d;
    end
  end

  assign rvalid    = rv_q;
  assign rdata     = rd_q;
  assign ce_pulse  = ce_q;
  assign ce_addr   = cea_q;
  assign exc_valid = exc_q;
  assign exc_vec   = vec_q;
  assign checkstop = chk_state;
  assign intc_req  = irq_q;
  assign wr_err    = werr_q;

endmodule

// File: rtl/ecc_sram_chk.sv
module ecc_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic              ready,
  input logic              rvalid,
  input logic              ce_pulse,
  input logic [ADDR_W-1:0] ce_addr,
  input logic              exc_valid,
  input logic [1:0]        exc_vec,
  input logic              checkstop,
  input logic              intc_req,
  input logic              wr_err
);

  // R1: once up, only a stop can take ready down
  p_ready_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (ready || checkstop));

  // R3: read data only follows an accepted read two edges back
  p_rd_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(req && !we && ready, 2));

  // R4: recorded address changes only with a correction
  p_ce_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_pulse |-> $stable(ce_addr));

  // R5: a read is never both corrected and uncorrectable
  p_ce_not_ue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ce_pulse |-> (!exc_valid && !intc_req));

  // R6: exceptions accompany returned reads
  p_exc_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> rvalid);

  // R7: a signalled exception always carries a vector
  p_vec_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_vec != 2'd0));

  // R8: stop state is terminal and blocks access
  p_stop_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop |=> checkstop);
  p_stop_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop |-> !ready);

  // R9: interrupt request only on an uncorrectable read
  p_irq_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    intc_req |-> (rvalid && (exc_valid || checkstop)));

  // R10: write error only follows a write request
  p_werr_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(req && we && ready));

endmodule

bind ecc_sram ecc_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .we        (we),
  .ready     (ready),
  .rvalid    (rvalid),
  .ce_pulse  (ce_pulse),
  .ce_addr   (ce_addr),
  .exc_valid (exc_valid),
  .exc_vec   (exc_vec),
  .checkstop (checkstop),
  .intc_req  (intc_req),
  .wr_err    (wr_err)
);

// File: tb/ecc_sram_tb.sv
module ecc_sram_tb;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int DW    = 64;
  localparam int CWW   = 72;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           req, we, ifetch, msr_ee, msr_me, rpt_en;
  logic [AW-1:0]  addr;
  logic [DW-1:0]  wdata;
  logic [7:0]     wbe;
  logic [CWW-1:0] inj_mask;
  logic           ready, rvalid, ce_pulse, exc_valid, checkstop, intc_req, wr_err;
  logic [DW-1:0]  rdata;
  logic [AW-1:0]  ce_addr;
  logic [1:0]     exc_vec;

  ecc_sram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .wbe(wbe), .inj_mask(inj_mask), .ifetch(ifetch), .msr_ee(msr_ee),
    .msr_me(msr_me), .rpt_en(rpt_en), .ready(ready), .rvalid(rvalid),
    .rdata(rdata), .ce_pulse(ce_pulse), .ce_addr(ce_addr), .exc_valid(exc_valid),
    .exc_vec(exc_vec), .checkstop(checkstop), .intc_req(intc_req), .wr_err(wr_err)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [DW-1:0] exp_mem [DEPTH];
  int            exp_nf  [DEPTH];

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_vec_f(input bit ee, input bit me, input bit ifx);
    if (ee) return ifx ? 2'd3 : 2'd2;
    return me ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [CWW-1:0] mask_of(input int nflip);
    logic [CWW-1:0] m;
    int b1, b2;
    m  = '0;
    b1 = $urandom_range(0, CWW-1);
    b2 = (b1 + 1 + $urandom_range(0, CWW-2)) % CWW;
    if (nflip >= 1) m[b1] = 1'b1;
    if (nflip >= 2) m[b2] = 1'b1;
    return m;
  endfunction

  task automatic idle();
    req = 1'b0; we = 1'b0; wbe = 8'hFF; inj_mask = '0; ifetch = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [7:0] be, input logic [CWW-1:0] m);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; wbe = be; inj_mask = m;
    @(negedge clk);
    idle();
    if (be == 8'hFF) begin
      check("R10 full write wr_err", {63'd0, wr_err}, 64'd0);
      exp_mem[a] = d;
      exp_nf[a]  = $countones(m);
    end else begin
      check("R10 partial write wr_err", {63'd0, wr_err}, 64'd1);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit ifx);
    req = 1'b1; we = 1'b0; addr = a; ifetch = ifx;
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  // read and compare against the model
  task automatic read_chk(input logic [AW-1:0] a, input bit ifx, input string tag);
    logic [1:0] ev;
    ev = exp_vec_f(msr_ee, msr_me, ifx);
    do_read(a, ifx);
    check({tag, " rvalid"}, {63'd0, rvalid}, 64'd1);
    if (exp_nf[a] == 0) begin
      check({tag, " R3 data"}, rdata, exp_mem[a]);
      check({tag, " R3 no ce"}, {63'd0, ce_pulse}, 64'd0);
      check({tag, " R3 no exc"}, {62'd0, exc_valid, intc_req}, 64'd0);
    end else if (exp_nf[a] == 1) begin
      check({tag, " R4 data"}, rdata, exp_mem[a]);
      check({tag, " R4 ce"}, {63'd0, ce_pulse}, 64'd1);
      check({tag, " R4 ce_addr"}, {58'd0, ce_addr}, {58'd0, a});
      check({tag, " R4 no exc"}, {63'd0, exc_valid}, 64'd0);
    end else begin
      check({tag, " R5 no ce"}, {63'd0, ce_pulse}, 64'd0);
      check({tag, " R6 R7 exc"}, {61'd0, exc_valid, exc_vec}, {61'd0, 1'b1, ev});
      check({tag, " R9 irq"}, {63'd0, intc_req}, {63'd0, rpt_en});
    end
  endtask

  task automatic reset_and_scrub(input string tag);
    int cyc;
    logic seen_bad;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({tag, " R1 reset ready"}, {60'd0, ready, rvalid, checkstop, ce_pulse}, 64'd0);
    rst_n = 1'b1;
    seen_bad = 1'b0;
    for (int i = 1; i <= DEPTH + 1; i++) begin
      if (i < DEPTH) begin
        req = 1'b1; we = i[0]; wbe = 8'h00; addr = AW'(i);
      end else begin
        idle();
      end
      @(negedge clk);
      if (ready || rvalid || wr_err) seen_bad = 1'b1;
    end
    check({tag, " R1 held off during scrub"}, {63'd0, seen_bad}, 64'd0);
    @(negedge clk);
    check({tag, " R1 ready after scrub"}, {63'd0, ready}, 64'd1);
    for (int j = 0; j < DEPTH; j++) begin
      exp_mem[j] = '0;
      exp_nf[j]  = 0;
    end
    cyc = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d0;
    void'($urandom(32'h1F2E3D4C));
    msr_ee = 1'b1; msr_me = 1'b1; rpt_en = 1'b0; addr = '0; wdata = '0;
    idle();
    @(negedge clk);
    reset_and_scrub("first");

    // R2: scrubbed contents
    for (int a = 0; a < DEPTH; a++) read_chk(AW'(a), 1'b0, "R2 scrub");

    // R3 directed
    do_write(6'd5, 64'hA5A5_0F0F_1234_5678, 8'hFF, '0);
    read_chk(6'd5, 1'b0, "R3 plain");
    @(negedge clk);
    check("R3 rvalid single cycle", {63'd0, rvalid}, 64'd0);

    // R4: single flips at data and check-bit edges
    do_write(6'd10, 64'hDEAD_BEEF_CAFE_F00D, 8'hFF, 72'd1);
    read_chk(6'd10, 1'b0, "R4 bit0");
    @(negedge clk);
    check("R4 ce pulse width", {63'd0, ce_pulse}, 64'd0);
    check("R4 ce_addr held", {58'd0, ce_addr}, 64'd10);
    do_write(6'd11, 64'h0123_4567_89AB_CDEF, 8'hFF, 72'd1 << 63);
    read_chk(6'd11, 1'b1, "R4 bit63");
    do_write(6'd12, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 72'd1 << 64);
    read_chk(6'd12, 1'b0, "R4 bit64");
    do_write(6'd13, 64'h8000_0000_0000_0001, 8'hFF, 72'd1 << 71);
    read_chk(6'd13, 1'b0, "R4 bit71");
    // R11: not scrubbed back
    read_chk(6'd13, 1'b0, "R11 reread");

    // R6, R9: data storage with reporting
    msr_ee = 1'b1; msr_me = 1'b0; rpt_en = 1'b1;
    do_write(6'd20, 64'h5555_AAAA_5555_AAAA, 8'hFF, (72'd1 << 3) | (72'd1 << 40));
    read_chk(6'd20, 1'b0, "R6 data");
    // R6, R9: instruction storage without reporting
    rpt_en = 1'b0;
    do_write(6'd21, 64'h1111_2222_3333_4444, 8'hFF, (72'd1 << 71) | (72'd1 << 0));
    read_chk(6'd21, 1'b1, "R6 fetch");
    // R7: machine check, both access types
    msr_ee = 1'b0; msr_me = 1'b1; rpt_en = 1'b1;
    read_chk(6'd21, 1'b1, "R7 fetch");
    read_chk(6'd20, 1'b0, "R7 data");

    // R10: partial write rejected
    msr_ee = 1'b1;
    d0 = 64'hFACE_B00C_0000_1111;
    do_write(6'd30, d0, 8'hFF, '0);
    do_write(6'd30, 64'h0, 8'h0F, '0);
    read_chk(6'd30, 1'b0, "R10 unchanged");
    do_write(6'd30, 64'h0, 8'h7F, '0);
    read_chk(6'd30, 1'b0, "R10 unchanged again");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [AW-1:0] ra;
      op = $urandom_range(0, 9);
      ra = AW'($urandom_range(0, DEPTH-1));
      msr_ee = 1'($urandom_range(0, 1));
      msr_me = msr_ee ? 1'($urandom_range(0, 1)) : 1'b1;
      rpt_en = 1'($urandom_range(0, 1));
      if (op < 5) begin
        logic [DW-1:0] rd;
        rd = {$urandom(), $urandom()};
        do_write(ra, rd, 8'hFF, mask_of($urandom_range(0, 2)));
      end else if (op == 5) begin
        do_write(ra, {$urandom(), $urandom()}, 8'($urandom_range(0, 254)), '0);
      end else begin
        read_chk(ra, 1'($urandom_range(0, 1)), "rand");
      end
    end

    // R8: terminal stop
    msr_ee = 1'b0; msr_me = 1'b0; rpt_en = 1'b1;
    do_write(6'd40, 64'h7777_0000_7777_0000, 8'hFF, (72'd1 << 9) | (72'd1 << 66));
    do_write(6'd41, 64'h0000_9999_0000_9999, 8'hFF, '0);
    do_read(6'd40, 1'b0);
    check("R8 stop set", {63'd0, checkstop}, 64'd1);
    check("R8 no exc", {63'd0, exc_valid}, 64'd0);
    check("R9 irq with stop", {63'd0, intc_req}, 64'd1);
    check("R8 ready low", {63'd0, ready}, 64'd0);
    msr_ee = 1'b1;
    do_read(6'd41, 1'b0);
    check("R8 read ignored", {63'd0, rvalid}, 64'd0);
    req = 1'b1; we = 1'b1; wbe = 8'h00; addr = 6'd41;
    @(negedge clk);
    idle();
    check("R8 write ignored", {63'd0, wr_err}, 64'd0);
    repeat (5) @(negedge clk);
    check("R8 stop sticky", {63'd0, checkstop}, 64'd1);

    // reset clears the stop and re-scrubs
    reset_and_scrub("second");
    check("R8 stop cleared", {63'd0, checkstop}, 64'd0);
    read_chk(6'd40, 1'b0, "R2 rescrub");
    read_chk(6'd41, 1'b0, "R2 rescrub");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule